// File: doc/BRIEF.md
# Message Double-Buffer Controller

This block steers a stream of incoming data words into two buffers, A and B, that take turns. Each accepted word is written at the index the controller provides, into the buffer it currently selects. A buffer closes when its last entry is written, or earlier when the word carries an end-of-message marker. A closed buffer stays full until the consumer hands it back with that buffer's own release strobe. The write index then starts again at zero for the next fill.

After a buffer closes, the controller moves to the other buffer if that buffer is free. If the other buffer is still full, the controller keeps pointing at the full one and drops incoming words until a release arrives. Two sticky error flags record problems and have no effect on operation:
- The overflow flag records a buffer that filled up with no end-of-message.
- The overrun flag records a word that arrived while no buffer was free.

Each flag has its own clear strobe. Data storage and bus transfer belong to the neighbouring logic.

Top module: `mbuf_msg_ctrl`

## Requirements
- R1: After reset, `sel_b` is 0 (buffer A selected), `full_a` and `full_b` are 0, `wr_idx` is 0, and both flags are 0.
- R2: When `in_valid` is high and the selected buffer is not full, `wr_ok` is high in that same cycle and `wr_idx` gives the entry written. `wr_idx` then advances by one.
- R3: A word written at index DEPTH-1 closes the selected buffer. Its full bit (bit `full_a` for A, `full_b` for B) rises on the next cycle. If the other buffer is free, `sel_b` switches to it and `wr_idx` returns to 0.
- R4: An accepted word with `in_eom` high closes the selected buffer at any index, so a partly written buffer is marked full. `wr_idx` returns to 0.
- R5: While the selected buffer is full, meaning both buffers are full, incoming words are refused: `wr_ok` is low, and `wr_idx` and the full bits do not change because of them.
- R6: `rel_a` empties a full buffer A and `rel_b` empties a full buffer B. Both may be asserted in the same cycle. When the controller is waiting on a full selection and the other buffer is released, `sel_b` moves to the released buffer.
- R7: A release strobe for a buffer that is not full has no effect.
- R8: `ovf_flag` rises after a word is accepted at index DEPTH-1 without `in_eom`. A word at that index that carries `in_eom` closes the buffer without raising the flag.
- R9: `ovr_flag` rises after any cycle in which `in_valid` is high and the word is refused.
- R10: Each flag stays set until its own clear strobe (`clr_ovr` or `clr_ovf`) is high for a cycle. If a new error arrives in the same cycle as the clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An incoming word is present this cycle |
| in_eom | input | 1 | The incoming word ends a message |
| rel_a | input | 1 | Release strobe for buffer A |
| rel_b | input | 1 | Release strobe for buffer B |
| clr_ovr | input | 1 | Clears the overrun flag |
| clr_ovf | input | 1 | Clears the overflow flag |
| wr_ok | output | 1 | The incoming word is accepted and written this cycle |
| wr_idx | output | IDX_W | Entry index for the word being written |
| sel_b | output | 1 | Selected buffer: 0 = A, 1 = B |
| full_a | output | 1 | Buffer A is full and waiting for release |
| full_b | output | 1 | Buffer B is full and waiting for release |
| ovr_flag | output | 1 | Sticky overrun flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench builds the controller with DEPTH set to 8 rather than the default 64. At that depth a complete fill takes eight words, so the directed sequence can reach each of the following within a few hundred cycles:
- natural overflow,
- end-of-message on the last entry,
- the waiting state with both buffers full,
- a simultaneous double release.

A pseudo-random phase then mixes words, markers, releases and clears at that depth. This phase exercises switching in both directions and the case where a clear and a new error land in the same cycle.

// File: rtl/mbuf_pkg.sv
package mbuf_pkg;
   typedef enum logic {
      BUF_A = 1'b0,
      BUF_B = 1'b1
   } buf_id_e;

   function automatic buf_id_e other_buf(input buf_id_e b);
      return (b == BUF_A) ? BUF_B : BUF_A;
   endfunction
endpackage

// File: rtl/mbuf_idx_ctr.sv
module mbuf_idx_ctr #(
   parameter int DEPTH = 64,
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             restart,
   output logic [IDX_W-1:0] idx,
   output logic             at_last
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   always_ff @(posedge clk) begin
      if (!rst_n)       idx <= '0;
      else if (restart) idx <= '0;
      else if (adv)     idx <= idx + 1'b1;
   end

   assign at_last = (idx == LAST);
endmodule

// File: rtl/mbuf_hold_bit.sv
module mbuf_hold_bit #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   logic q_nxt;

   generate
      if (SET_WINS) begin : g_set_first
         always_comb q_nxt = set | (q & ~clr);
      end else begin : g_clr_first
         always_comb q_nxt = ~clr & (set | q);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= q_nxt;
   end
endmodule

// File: rtl/mbuf_msg_ctrl.sv
module mbuf_msg_ctrl
   import mbuf_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_eom,
   input  logic             rel_a,
   input  logic             rel_b,
   input  logic             clr_ovr,
   input  logic             clr_ovf,
   output logic             wr_ok,
   output logic [IDX_W-1:0] wr_idx,
   output logic             sel_b,
   output logic             full_a,
   output logic             full_b,
   output logic             ovr_flag,
   output logic             ovf_flag
);
   localparam int NBUF = 2;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("mbuf_msg_ctrl: DEPTH must be at least 2");
      end
      if (IDX_W < $clog2(DEPTH)) begin : g_bad_width
         $error("mbuf_msg_ctrl: IDX_W too narrow for DEPTH");
      end
   endgenerate

   buf_id_e          sel_q;
   logic [NBUF-1:0]  full_q;
   logic [NBUF-1:0]  rel_v;
   logic [NBUF-1:0]  full_nxt;
   logic             sel_full;
   logic             accept;
   logic             at_last;
   logic             close;
   logic             ovr_set;
   logic             ovf_set;

   assign rel_v    = {rel_b, rel_a};
   assign sel_full = full_q[sel_q];
   assign accept   = in_valid & ~sel_full;
   assign close    = accept & (in_eom | at_last);
   assign ovr_set  = in_valid & sel_full;
   assign ovf_set  = accept & at_last & ~in_eom;

   mbuf_idx_ctr #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_idx (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (accept),
      .restart (close),
      .idx     (wr_idx),
      .at_last (at_last)
   );

   generate
      for (genvar i = 0; i < NBUF; i++) begin : g_slot
         logic fill_here;
         assign fill_here   = close & (sel_q == buf_id_e'(i));
         assign full_nxt[i] = fill_here | (full_q[i] & ~rel_v[i]);
         mbuf_hold_bit #(.SET_WINS(1'b1)) u_full (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (fill_here),
            .clr   (rel_v[i] & full_q[i]),
            .q     (full_q[i])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         sel_q <= BUF_A;
      else if (full_nxt[sel_q] && !full_nxt[other_buf(sel_q)])
         sel_q <= other_buf(sel_q);
   end

   mbuf_hold_bit #(.SET_WINS(1'b1)) u_ovr (
      .clk (clk), .rst_n (rst_n), .set (ovr_set), .clr (clr_ovr), .q (ovr_flag)
   );

   mbuf_hold_bit #(.SET_WINS(1'b1)) u_ovf (
      .clk (clk), .rst_n (rst_n), .set (ovf_set), .clr (clr_ovf), .q (ovf_flag)
   );

   assign wr_ok  = accept;
   assign sel_b  = sel_q;
   assign full_a = full_q[0];
   assign full_b = full_q[1];
endmodule

// File: rtl/mbuf_msg_ctrl_chk.sv
module mbuf_msg_ctrl_chk #(
   parameter int DEPTH = 64,
   parameter int IDX_W = $clog2(DEPTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_eom,
   input logic             rel_a,
   input logic             rel_b,
   input logic             clr_ovr,
   input logic             clr_ovf,
   input logic             wr_ok,
   input logic [IDX_W-1:0] wr_idx,
   input logic             sel_b,
   input logic             full_a,
   input logic             full_b,
   input logic             ovr_flag,
   input logic             ovf_flag
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   // R2
   accept_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && !in_eom && wr_idx != LAST) |=> (wr_idx == $past(wr_idx) + 1'b1));

   // R4
   eom_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && in_eom) |=> (wr_idx == '0));

   // R5
   no_wait_with_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((sel_b ? full_b : full_a)) |-> (full_a && full_b));

   // R6
   full_a_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full_a && !rel_a) |=> full_a);

   // R6
   full_b_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full_b && !rel_b) |=> full_b);

   // R8
   overflow_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && wr_idx == LAST && !in_eom) |=> ovf_flag);

   // R9
   overrun_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !wr_ok) |=> ovr_flag);

   // R10
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_flag && !clr_ovr) |=> ovr_flag);

   // R10
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !clr_ovf) |=> ovf_flag);
endmodule

bind mbuf_msg_ctrl mbuf_msg_ctrl_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/mbuf_msg_ctrl_tb.sv
module mbuf_msg_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int D = 8;
   localparam int IW = $clog2(D);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 0, in_eom = 0, rel_a = 0, rel_b = 0, clr_ovr = 0, clr_ovf = 0;
   logic wr_ok, sel_b, full_a, full_b, ovr_flag, ovf_flag;
   logic [IW-1:0] wr_idx;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   int m_sel = 0, m_idx = 0, m_ovr = 0, m_ovf = 0;
   int m_full[2] = '{0, 0};

   always #(CLK_PERIOD/2) clk = ~clk;

   mbuf_msg_ctrl #(.DEPTH(D)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eom(in_eom),
      .rel_a(rel_a), .rel_b(rel_b), .clr_ovr(clr_ovr), .clr_ovf(clr_ovf),
      .wr_ok(wr_ok), .wr_idx(wr_idx), .sel_b(sel_b), .full_a(full_a),
      .full_b(full_b), .ovr_flag(ovr_flag), .ovf_flag(ovf_flag)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic step(input bit v, input bit e, input bit ra, input bit rb,
                       input bit co, input bit cf, input string tag);
      bit nf[2];
      bit acc, last, cls;
      in_valid = v; in_eom = e; rel_a = ra; rel_b = rb; clr_ovr = co; clr_ovf = cf;
      #1;
      acc = v && (m_full[m_sel] == 0);
      chk(tag, "wr_ok", int'(wr_ok), int'(acc));
      chk(tag, "wr_idx", int'(wr_idx), m_idx);
      chk(tag, "sel_b", int'(sel_b), m_sel);
      chk(tag, "full_a", int'(full_a), m_full[0]);
      chk(tag, "full_b", int'(full_b), m_full[1]);
      chk(tag, "ovr_flag", int'(ovr_flag), m_ovr);
      chk(tag, "ovf_flag", int'(ovf_flag), m_ovf);
      @(posedge clk);
      last = (m_idx == D - 1);
      cls  = acc && (e || last);
      nf[0] = (m_full[0] != 0 && !ra) || (cls && m_sel == 0);
      nf[1] = (m_full[1] != 0 && !rb) || (cls && m_sel == 1);
      if (v && !acc)        m_ovr = 1;
      else if (co)          m_ovr = 0;
      if (acc && last && !e) m_ovf = 1;
      else if (cf)          m_ovf = 0;
      if (cls)      m_idx = 0;
      else if (acc) m_idx = m_idx + 1;
      m_full[0] = nf[0];
      m_full[1] = nf[1];
      if (nf[m_sel] && !nf[1 - m_sel]) m_sel = 1 - m_sel;
      @(negedge clk);
   endtask

   initial begin
      bit [15:0] lfsr;
      lfsr = 16'hACE1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      step(0,0,0,0,0,0,"R1");
      // R2: plain writes into A
      for (int i = 0; i < 3; i++) step(1,0,0,0,0,0,"R2");
      // R4: early close by end-of-message at index 3
      step(1,1,0,0,0,0,"R4");
      step(0,0,0,0,0,0,"R4");
      // R7: release of B while B is not full
      step(0,0,0,1,0,0,"R7");
      step(0,0,0,0,0,0,"R7");
      // R3 / R8: fill B completely without a marker
      for (int i = 0; i < D; i++) step(1,0,0,0,0,0,"R3");
      step(0,0,0,0,0,0,"R8");
      // R5 / R9: both buffers full, words are dropped
      step(1,0,0,0,0,0,"R5");
      step(1,1,0,0,0,0,"R9");
      // R10: clear and new overrun in the same cycle keep the flag
      step(1,0,0,0,1,0,"R10");
      step(0,0,0,0,1,1,"R10");
      step(0,0,0,0,0,0,"R10");
      // R6: release A while waiting, selection moves to A
      step(0,0,1,0,0,0,"R6");
      step(1,0,0,0,0,0,"R6");
      // R8: fill A to the last entry with a marker there, no overflow
      for (int i = 0; i < D - 2; i++) step(1,0,0,0,0,0,"R8");
      step(1,1,0,0,0,0,"R8");
      step(0,0,0,0,0,0,"R8");
      // R6: double release
      step(0,0,1,1,0,0,"R6");
      step(0,0,0,0,0,0,"R6");
      step(1,0,0,0,0,0,"R6");
      // Mixed traffic
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[0] | lfsr[1], lfsr[2] & lfsr[3] & lfsr[4],
              lfsr[5] & lfsr[6], lfsr[7] & lfsr[8],
              lfsr[9] & lfsr[10] & lfsr[11], lfsr[12] & lfsr[13] & lfsr[14], "R2");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule